// File: doc/BRIEF.md
# Six-Pin Bidirectional Port Controller

This block is a small register-mapped I/O port for an eight-bit CPU bus. It owns six pins. For each pin it holds a direction bit and an output latch bit. It produces the pad output value and an active-high output enable. It also returns the pin levels to software after they pass through a synchronizer. An external per-pin analog-select mask forces the pin-level read to zero for pins that belong to an analog function. It does not change how the pin is driven.

Three byte registers sit on the bus. The pin register is at address 0. A read returns the synchronized pin levels, and a write loads the output latch. The latch register is at address 1 and reads back the stored latch value, so read-modify-write cycles on it are safe. The direction register is at address 2. The register bits above the six pins are not wasted. Bit 7 of the pin register and bits 7 and 6 of the latch register are weak pull-up enables for three other ports, brought out as pins.

Top module: `pio_port_ctl`

## Requirements
- R1: A synchronous active-low reset sets all six direction bits to 1 and clears the latch and all three pull-up enables. After reset, `pin_oe` is 0, `pin_out` is 0, the direction register reads 8'h3F and the latch register reads 8'h00.
- R2: A write to address 2 loads the direction bits from data bits 5:0. `pin_oe[i]` is the inverse of direction bit i. Data bits 7:6 of address 2 always read as 0.
- R3: `pin_out` always carries the output latch. A write to address 0 or to address 1 loads the latch from data bits 5:0.
- R4: A read of address 1 returns the latch in bits 5:0, independent of the pin levels.
- R5: A read of address 0 returns in bits 5:0 the pin levels delayed by a two-flop synchronizer. A pin change applied before clock edge k becomes readable after edge k+1. Bit i reads 0 whenever `ana_sel[i]` is 1, and bit 6 reads 0.
- R6: Bit 7 written to address 0 sets `pu_en_a`. Bit 7 of an address 0 read returns `pu_en_a`.
- R7: Bit 7 written to address 1 sets `pu_en_b`, and bit 6 sets `pu_en_c`. An address 1 read returns them in those same bit positions.
- R8: `ana_sel` has no effect on `pin_oe` or `pin_out`. A pin in analog mode is driven whenever its direction bit is 0.
- R9: Address 3 reads as 8'h00, and a write to it changes no output and no register.
- R10: A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A cycle without both high, including a read, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 pin, 1 latch, 2 direction, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| ana_sel | input | 6 | Per-pin analog mode; 1 masks the pin read to 0 |
| pin_in | input | 6 | Asynchronous pin levels |
| pin_out | output | 6 | Output latch value to the pads |
| pin_oe | output | 6 | Pad driver enable, 1 = drive |
| pu_en_a | output | 1 | Pull-up enable, first other port |
| pu_en_b | output | 1 | Pull-up enable, second other port |
| pu_en_c | output | 1 | Pull-up enable, third other port |

## Verification
The pin register is read while the pin levels differ from the latch. This separates the pin-read path from the latch-read path, and the latch register is read under the same condition. A pin change is sampled one edge and then two edges after it is applied, which checks the synchronizer depth exactly. The analog mask is swept through all-clear, the reset pattern and all-set, both with the drivers on and with them off. This shows that the mask gates reads only. Writes with the strobe low and writes to the unused address are followed by read-back, to confirm that nothing moved.

// File: rtl/pio_pkg.sv
// Package: shared constants and register-select type for the port controller.
// Assumes an eight-bit bus and a two-bit register address.
package pio_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } pio_sel_e;

    // Bit positions of the pull-up enables in the register bytes.
    localparam int PU_A_BIT = DATA_W - 1;   // in the pin register
    localparam int PU_B_BIT = DATA_W - 1;   // in the latch register
    localparam int PU_C_BIT = DATA_W - 2;   // in the latch register
endpackage

// File: rtl/pio_sync.sv
// Module: pio_sync
// Multi-stage flop synchronizer for a bus of independent asynchronous bits.
// Assumes STAGES >= 1; each bit is synchronized on its own, no coherency.
module pio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d_async;
            end
        end else begin : g_next
            // Later stages: pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
// Module: pio_regs
// Holds the direction bits, output latch and the three pull-up enables and
// applies bus writes. Assumes wr_en is already qualified by select and write.
module pio_regs
    import pio_pkg::*;
#(
    parameter int PIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  pio_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PIN_W-1:0]  dir_q,
    output logic [PIN_W-1:0]  lat_q,
    output logic              pu_a_q,
    output logic              pu_b_q,
    output logic              pu_c_q
);
    // Direction register: all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= '1;
        else if (wr_en && wr_sel == SEL_DIR) dir_q <= wr_data[PIN_W-1:0];
    end

    // Output latch: loaded through either the pin or the latch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (wr_en && (wr_sel == SEL_PIN || wr_sel == SEL_LAT)) begin
            lat_q <= wr_data[PIN_W-1:0];
        end
    end

    // Pull-up enable carried in the top bit of the pin register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pu_a_q <= 1'b0;
        else if (wr_en && wr_sel == SEL_PIN) pu_a_q <= wr_data[PU_A_BIT];
    end

    // Pull-up enables carried in the top two bits of the latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_b_q <= 1'b0;
            pu_c_q <= 1'b0;
        end else if (wr_en && wr_sel == SEL_LAT) begin
            pu_b_q <= wr_data[PU_B_BIT];
            pu_c_q <= wr_data[PU_C_BIT];
        end
    end
endmodule

// File: rtl/pio_rd_mux.sv
// Module: pio_rd_mux
// Builds the read byte for the selected register; masks analog pins on the
// pin-level read. Assumes PIN_W <= DATA_W-2 so the pull-up bits are free.
module pio_rd_mux
    import pio_pkg::*;
#(
    parameter int PIN_W = 6
) (
    input  pio_sel_e          rd_sel,
    input  logic [PIN_W-1:0]  pins_sync,
    input  logic [PIN_W-1:0]  ana_mask,
    input  logic [PIN_W-1:0]  dir_q,
    input  logic [PIN_W-1:0]  lat_q,
    input  logic              pu_a_q,
    input  logic              pu_b_q,
    input  logic              pu_c_q,
    output logic [DATA_W-1:0] rd_data
);
    // Select and assemble the byte; unimplemented bits read as zero.
    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_PIN: begin
                rd_data[PIN_W-1:0] = pins_sync & ~ana_mask;
                rd_data[PU_A_BIT]  = pu_a_q;
            end
            SEL_LAT: begin
                rd_data[PIN_W-1:0] = lat_q;
                rd_data[PU_B_BIT]  = pu_b_q;
                rd_data[PU_C_BIT]  = pu_c_q;
            end
            SEL_DIR:  rd_data[PIN_W-1:0] = dir_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pio_port_ctl.sv
// Module: pio_port_ctl (top)
// Six-pin register-mapped bidirectional port with analog read masking and
// spare-bit pull-up enables. Assumes pin_in is asynchronous to clk and that
// ana_sel is quasi-static and synchronous to clk.
module pio_port_ctl
    import pio_pkg::*;
#(
    parameter int PIN_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  ana_sel,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              pu_en_a,
    output logic              pu_en_b,
    output logic              pu_en_c
);
    pio_sel_e         sel;
    logic             wr_en;
    logic [PIN_W-1:0] pins_sync;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] lat_q;
    logic             pu_a_q, pu_b_q, pu_c_q;

    assign sel   = pio_sel_e'(bus_addr);
    assign wr_en = bus_sel && bus_wr;

    pio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pins_sync)
    );

    pio_regs #(.PIN_W(PIN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .pu_a_q  (pu_a_q),
        .pu_b_q  (pu_b_q),
        .pu_c_q  (pu_c_q)
    );

    pio_rd_mux #(.PIN_W(PIN_W)) u_rd (
        .rd_sel    (sel),
        .pins_sync (pins_sync),
        .ana_mask  (ana_sel),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .pu_a_q    (pu_a_q),
        .pu_b_q    (pu_b_q),
        .pu_c_q    (pu_c_q),
        .rd_data   (bus_rdata)
    );

    // Pad drive: the direction bit alone gates the driver, analog or not.
    assign pin_oe  = ~dir_q;
    assign pin_out = lat_q;
    assign pu_en_a = pu_a_q;
    assign pu_en_b = pu_b_q;
    assign pu_en_c = pu_c_q;
endmodule

// File: rtl/pio_port_ctl_chk.sv
// Module: pio_port_ctl_chk
// Port-level property checker for pio_port_ctl, bound to every instance.
module pio_port_ctl_chk #(
    parameter int PIN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic [PIN_W-1:0] ana_sel,
    input logic [PIN_W-1:0] pin_out,
    input logic [PIN_W-1:0] pin_oe,
    input logic             pu_en_a,
    input logic             pu_en_b,
    input logic             pu_en_c
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 &&
                          {pu_en_a, pu_en_b, pu_en_c} == 3'b000));

    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2) |=>
            pin_oe == ~$past(bus_wdata[PIN_W-1:0]));

    a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=>
            pin_out == $past(bus_wdata[PIN_W-1:0]));

    a_r5_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd0) |->
            ((bus_rdata[PIN_W-1:0] & ana_sel) == '0 && bus_rdata[6] == 1'b0));

    a_r6_pull_a: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd0) |=> pu_en_a == $past(bus_wdata[7]));

    a_r7_pull_bc: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=>
            {pu_en_b, pu_en_c} == $past(bus_wdata[7:6]));

    a_r9_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd3) |-> bus_rdata == 8'h00);

    a_r10_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr != 2'd3) |=>
            ($stable(pin_out) && $stable(pin_oe) &&
             $stable({pu_en_a, pu_en_b, pu_en_c})));
endmodule

bind pio_port_ctl pio_port_ctl_chk #(.PIN_W(PIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ana_sel   (ana_sel),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pu_en_a   (pu_en_a),
    .pu_en_b   (pu_en_b),
    .pu_en_c   (pu_en_c)
);

// File: tb/pio_port_ctl_bench.sv
`timescale 1ns/1ps
module pio_port_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [5:0] ana_sel = 6'b101111;
    logic [5:0] pin_in = 6'h00;
    logic [5:0] pin_out, pin_oe;
    logic       pu_en_a, pu_en_b, pu_en_c;

    int total = 0;
    int bad   = 0;
    bit live  = 0;

    always #5 clk = ~clk;

    pio_port_ctl u_pio_port_ctl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ana_sel(ana_sel), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pu_en_a(pu_en_a), .pu_en_b(pu_en_b), .pu_en_c(pu_en_c)
    );

    // Behavioural reference model: plain integers and a sample history queue.
    int m_dir, m_lat, m_pa, m_pb, m_pc;
    int m_hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 63; m_lat = 0; m_pa = 0; m_pb = 0; m_pc = 0;
            m_hist = '{0, 0};
        end else begin
            m_hist.push_back(int'(pin_in));
            void'(m_hist.pop_front());
            if (bus_sel && bus_wr) begin
                if (bus_addr == 2'd0) begin
                    m_lat = bus_wdata % 64; m_pa = bus_wdata / 128;
                end else if (bus_addr == 2'd1) begin
                    m_lat = bus_wdata % 64; m_pb = bus_wdata / 128;
                    m_pc = (bus_wdata / 64) % 2;
                end else if (bus_addr == 2'd2) begin
                    m_dir = bus_wdata % 64;
                end
            end
        end
    end

    function automatic int model_read(int a);
        case (a)
            0: return (m_hist[0] & (63 - int'(ana_sel))) + 128 * m_pa;
            1: return m_lat + 128 * m_pb + 64 * m_pc;
            2: return m_dir;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            check("R2/R8 pin_oe", int'(pin_oe), 63 - m_dir);
            check("R3 pin_out", int'(pin_out), m_lat);
            check("R6/R7 pull-ups", {pu_en_a, pu_en_b, pu_en_c}, m_pa*4 + m_pb*2 + m_pc);
            check("R4/R5/R9 rdata", int'(bus_rdata), model_read(int'(bus_addr)));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
        @(negedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = 2'(a);
        #2 check(tag, int'(bus_rdata), exp);
    endtask

    task automatic do_reset();
        @(negedge clk); #1 rst_n = 0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
        live = 1;
        // R1 reset values
        rd(2, 8'h3F, "R1 dir reset");
        rd(1, 8'h00, "R1 latch reset");
        check("R1 oe reset", int'(pin_oe), 0);
        check("R1 out reset", int'(pin_out), 0);
        // R2 direction write, bits 7:6 unimplemented
        wr(2, 8'hCF);
        rd(2, 8'h0F, "R2 dir readback");
        check("R2 oe pattern", int'(pin_oe), 6'h30);
        // R3/R4 latch vs pins
        pin_in = 6'h05;
        wr(1, 8'h3A);
        check("R3 out after latch write", int'(pin_out), 6'h3A);
        rd(1, 8'h3A, "R4 latch reads latch not pins");
        wr(0, 8'h15);
        check("R3 out after pin-reg write", int'(pin_out), 6'h15);
        rd(1, 8'h15, "R3 latch via pin reg");
        // R5 synchronizer latency and analog mask
        ana_sel = 6'h00;
        rd(0, 8'h05, "R5 settled read");
        @(negedge clk); #1 pin_in = 6'h2A;
        @(negedge clk); #2 check("R5 one edge: still old", int'(bus_rdata), 8'h05);
        @(negedge clk); #2 check("R5 two edges: new", int'(bus_rdata), 8'h2A);
        #1 ana_sel = 6'h2F;
        #1 check("R5 masked", int'(bus_rdata), 8'h00);
        pin_in = 6'h3F;
        repeat (3) @(negedge clk);
        rd(0, 8'h10, "R5 reset-pattern mask");
        ana_sel = 6'h00;
        rd(0, 8'h3F, "R5 no mask");
        // R8 analog mask does not gate drivers
        ana_sel = 6'h3F;
        wr(2, 8'h00);
        check("R8 oe with all analog", int'(pin_oe), 6'h3F);
        check("R8 out with all analog", int'(pin_out), 6'h15);
        // R6 pin-register pull-up
        wr(0, 8'h80);
        check("R6 pu_en_a set", int'(pu_en_a), 1);
        rd(0, 8'h80, "R6 readback, pins masked");
        // R7 latch-register pull-ups
        wr(1, 8'hC7);
        check("R7 pull b/c set", {pu_en_b, pu_en_c}, 3);
        rd(1, 8'hC7, "R7 readback");
        wr(1, 8'h40);
        check("R7 pull b clear c set", {pu_en_b, pu_en_c}, 1);
        // R9 unused address
        wr(3, 8'hFF);
        rd(3, 8'h00, "R9 unused reads zero");
        rd(1, 8'h40, "R9 latch untouched");
        rd(2, 8'h00, "R9 dir untouched");
        // R10 write without select, read has no effect
        @(negedge clk); #1 bus_sel = 0; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'hFF;
        @(negedge clk); #1 bus_wr = 0;
        rd(2, 8'h00, "R10 unselected write ignored");
        rd(1, 8'h40, "R10 read has no side effect");
        check("R10 oe unchanged", int'(pin_oe), 6'h3F);
        // R1 mid-run reset
        bus_sel = 0;
        do_reset();
        rd(2, 8'h3F, "R1 dir after second reset");
        check("R1 pulls after second reset", {pu_en_a, pu_en_b, pu_en_c}, 0);
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule